// File: doc/BRIEF.md
# Masked Pattern Detector with Auto-Reset

This block watches the registered output of a wide accumulator and, in the same cycle that value appears, says whether it equals a reference pattern or the bitwise inverse of that pattern once a mask has removed the bits that do not matter. The pattern is either a fixed parameter or the live `cval` input. The mask is a fixed parameter, `cval` itself, or `cval` inverted and shifted up by one or two places. The shifted forms make the compare window follow a rounding point for convergent rounding.

On top of the two match flags the block keeps the previous cycle's flags. From them it drives overflow and underflow indications. It can also clear the accumulator by itself one cycle after a match, or one cycle after the first miss that follows a match. This gives terminal-count counters and saturation-free wrap detection without any logic outside the block. A parameter decides whether that automatic clear overrides a low accumulate enable or is gated by it. The accumulator is a plain adder register with an enable. It stands in for the arithmetic datapath.

Top module: `patmatch_acc`

## Requirements
- R1: A low `rst_n` or a high `res_clr` at a clock edge sets `acc_out` to zero and clears both remembered flags, so `ovf` and `udf` read 0 in the following cycle.
- R2: With `acc_en` high and no clear pending, `acc_out` becomes `acc_out + addend` modulo 2^W at the edge. With `acc_en` low and no clear, it holds.
- R3: `hit` is 1 in the same cycle as `acc_out` when every bit where the mask is 0 equals the pattern bit. A mask bit of 1 removes that bit from the compare. With the defaults (mask with only the two top bits 0, pattern 0), `hit` means the top two bits are 00.
- R4: `hit_inv` is 1 when every unmasked bit of `acc_out` equals the inverse of the pattern bit. With the defaults, this means the top two bits are 11.
- R5: `PAT_SRC` selects the pattern: `PAT_STATIC` uses parameter `PATTERN_INIT` (default 0), and `PAT_C` uses `cval`.
- R6: `MASK_SRC` selects the mask: `MSK_STATIC` uses `MASK_INIT` (default all ones with the two top bits 0), `MSK_C` uses `cval`, `MSK_NC_SHL1` uses `~cval` shifted left by 1, and `MSK_NC_SHL2` uses `~cval` shifted left by 2. In the shifted forms the bits shifted in are 0, so those low bits are always compared.
- R7: With `AUTO_MODE = AR_ON_HIT`, a cycle with `hit` high makes the next edge load zero into the accumulator instead of the sum.
- R8: With `AUTO_MODE = AR_ON_LEAVE`, a cycle with `hit` low that follows a cycle with `hit` high makes the next edge load zero.
- R9: With `AUTO_PRIO = PRIO_CLEAR`, an automatic clear happens even when `acc_en` is low. With `PRIO_ENABLE`, it happens only when `acc_en` is high, and otherwise the value holds.
- R10: `ovf` is 1 when the previous cycle had `hit` high and the current cycle has neither `hit` nor `hit_inv`.
- R11: `udf` is 1 when the previous cycle had `hit_inv` high and the current cycle has neither `hit_inv` nor `hit`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Accumulate enable |
| res_clr | input | 1 | Synchronous clear of accumulator and flag history |
| addend | input | W | Value added per enabled cycle |
| cval | input | W | Dynamic pattern/mask source |
| acc_out | output | W | Accumulator register |
| hit | output | 1 | Masked match against the pattern |
| hit_inv | output | 1 | Masked match against the inverted pattern |
| ovf | output | 1 | Left the pattern region without entering its inverse |
| udf | output | 1 | Left the inverse region without entering the pattern |

## Verification
The accumulate enable and the automatic clear can fall in the same edge. That edge decides whether the register takes the sum, zero or its old value. The bench provokes this by dropping `acc_en` in exactly the cycle where a terminal-count match, or a first miss after a match, is showing. The `PRIO_CLEAR` instance must still load zero, and the `PRIO_ENABLE` instance must keep its value. The overflow flag and a fresh match also meet in one cycle, when a wrap jumps directly from the pattern region into its inverse. There the bench expects no overflow.

// File: rtl/pd_pkg.sv
// Shared selector types for the pattern detector.
// Assumes: nothing; pure type definitions.
package pd_pkg;

    typedef enum logic {
        PAT_STATIC = 1'b0,
        PAT_C      = 1'b1
    } pat_src_e;

    typedef enum logic [1:0] {
        MSK_STATIC  = 2'd0,
        MSK_C       = 2'd1,
        MSK_NC_SHL1 = 2'd2,
        MSK_NC_SHL2 = 2'd3
    } mask_src_e;

    typedef enum logic [1:0] {
        AR_OFF      = 2'd0,
        AR_ON_HIT   = 2'd1,
        AR_ON_LEAVE = 2'd2
    } autorst_e;

    typedef enum logic {
        PRIO_CLEAR  = 1'b0,
        PRIO_ENABLE = 1'b1
    } arprio_e;

endpackage

// File: rtl/pd_srcsel.sv
// Chooses the pattern and mask presented to the comparator.
// Assumes: cval is stable for the cycle; selection is fixed at build time.
module pd_srcsel
    import pd_pkg::*;
#(
    parameter int          W            = 58,
    parameter pat_src_e    PAT_SRC      = PAT_STATIC,
    parameter mask_src_e   MASK_SRC     = MSK_STATIC,
    parameter logic [W-1:0] PATTERN_INIT = '0,
    parameter logic [W-1:0] MASK_INIT    = {2'b00, {(W-2){1'b1}}}
) (
    input  logic [W-1:0] cval,
    output logic [W-1:0] pat,
    output logic [W-1:0] mask
);

    // Pattern source mux.
    always_comb begin
        pat = (PAT_SRC == PAT_C) ? cval : PATTERN_INIT;
    end

    // Mask source mux; shifted forms fill the vacated low bits with 0.
    always_comb begin
        unique case (MASK_SRC)
            MSK_C:       mask = cval;
            MSK_NC_SHL1: mask = {~cval[W-2:0], 1'b0};
            MSK_NC_SHL2: mask = {~cval[W-3:0], 2'b00};
            default:     mask = MASK_INIT;
        endcase
    end

endmodule

// File: rtl/pd_compare.sv
// Bitwise masked comparison against a pattern and its inverse.
// Assumes: mask bit 1 means "ignore this bit".
module pd_compare #(
    parameter int W = 58
) (
    input  logic [W-1:0] value,
    input  logic [W-1:0] pat,
    input  logic [W-1:0] mask,
    output logic         hit,
    output logic         hit_inv
);

    logic [W-1:0] eq_bit;
    logic [W-1:0] ne_bit;

    // One compare cell per bit position.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign eq_bit[i] = mask[i] | (value[i] == pat[i]);
        assign ne_bit[i] = mask[i] | (value[i] != pat[i]);
    end

    // Reduce the per-bit results into the two flags.
    always_comb begin
        hit     = &eq_bit;
        hit_inv = &ne_bit;
    end

endmodule

// File: rtl/pd_history.sv
// Remembers last cycle's match flags; derives overflow, underflow and the
// automatic-clear request.
// Assumes: hit/hit_inv are computed from a registered value.
module pd_history
    import pd_pkg::*;
#(
    parameter autorst_e AUTO_MODE = AR_OFF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic res_clr,
    input  logic hit,
    input  logic hit_inv,
    output logic ovf,
    output logic udf,
    output logic auto_clr
);

    logic hit_d;
    logic inv_d;

    // Capture the flags of the current cycle for use in the next.
    always_ff @(posedge clk) begin
        if (!rst_n || res_clr) begin
            hit_d <= 1'b0;
            inv_d <= 1'b0;
        end else begin
            hit_d <= hit;
            inv_d <= hit_inv;
        end
    end

    // Leaving a region without landing in its opposite.
    always_comb begin
        ovf = hit_d & ~hit & ~hit_inv;
        udf = inv_d & ~hit_inv & ~hit;
    end

    // Automatic-clear request per mode.
    always_comb begin
        unique case (AUTO_MODE)
            AR_ON_HIT:   auto_clr = hit;
            AR_ON_LEAVE: auto_clr = ~hit & hit_d;
            default:     auto_clr = 1'b0;
        endcase
    end

    a_r10_ovf_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> ($past(hit) && !hit && !hit_inv));

    a_r11_udf_after_inv: assert property (@(posedge clk) disable iff (!rst_n)
        udf |-> ($past(hit_inv) && !hit_inv && !hit));

    a_r8_leave_needs_prior_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (AUTO_MODE == AR_ON_LEAVE && auto_clr) |-> ($past(hit) && !hit));

endmodule

// File: rtl/pd_accum.sv
// Accumulator register standing in for the arithmetic datapath.
// Assumes: res_clr outranks automatic clear, which outranks accumulation.
module pd_accum
    import pd_pkg::*;
#(
    parameter int      W         = 58,
    parameter arprio_e AUTO_PRIO = PRIO_CLEAR
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         res_clr,
    input  logic         en,
    input  logic         auto_clr,
    input  logic [W-1:0] addend,
    output logic [W-1:0] acc
);

    logic clear_now;

    // Decide whether the automatic request is honoured this edge.
    always_comb begin
        clear_now = auto_clr & ((AUTO_PRIO == PRIO_CLEAR) | en);
    end

    // Accumulator register update.
    always_ff @(posedge clk) begin
        if (!rst_n || res_clr) begin
            acc <= '0;
        end else if (clear_now) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc + addend;
        end
    end

    a_r1_sync_clear: assert property (@(posedge clk) disable iff (!rst_n)
        res_clr |=> (acc == '0));

    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !res_clr && !auto_clr) |=> $stable(acc));

    a_r9_clear_over_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (AUTO_PRIO == PRIO_CLEAR && auto_clr) |=> (acc == '0));

endmodule

// File: rtl/patmatch_acc.sv
// Top: accumulator with masked pattern / inverse-pattern detection,
// overflow/underflow flags and optional automatic clear.
// Assumes: all selectors are build-time parameters; cval is live.
module patmatch_acc
    import pd_pkg::*;
#(
    parameter int           W            = 58,
    parameter pat_src_e     PAT_SRC      = PAT_STATIC,
    parameter mask_src_e    MASK_SRC     = MSK_STATIC,
    parameter logic [W-1:0] PATTERN_INIT = '0,
    parameter logic [W-1:0] MASK_INIT    = {2'b00, {(W-2){1'b1}}},
    parameter autorst_e     AUTO_MODE    = AR_OFF,
    parameter arprio_e      AUTO_PRIO    = PRIO_CLEAR
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         acc_en,
    input  logic         res_clr,
    input  logic [W-1:0] addend,
    input  logic [W-1:0] cval,
    output logic [W-1:0] acc_out,
    output logic         hit,
    output logic         hit_inv,
    output logic         ovf,
    output logic         udf
);

    logic [W-1:0] pat;
    logic [W-1:0] mask;
    logic         auto_clr;

    pd_srcsel #(
        .W(W), .PAT_SRC(PAT_SRC), .MASK_SRC(MASK_SRC),
        .PATTERN_INIT(PATTERN_INIT), .MASK_INIT(MASK_INIT)
    ) u_sel (
        .cval(cval), .pat(pat), .mask(mask)
    );

    pd_compare #(.W(W)) u_cmp (
        .value(acc_out), .pat(pat), .mask(mask),
        .hit(hit), .hit_inv(hit_inv)
    );

    pd_history #(.AUTO_MODE(AUTO_MODE)) u_hist (
        .clk(clk), .rst_n(rst_n), .res_clr(res_clr),
        .hit(hit), .hit_inv(hit_inv),
        .ovf(ovf), .udf(udf), .auto_clr(auto_clr)
    );

    pd_accum #(.W(W), .AUTO_PRIO(AUTO_PRIO)) u_acc (
        .clk(clk), .rst_n(rst_n), .res_clr(res_clr), .en(acc_en),
        .auto_clr(auto_clr), .addend(addend), .acc(acc_out)
    );

    // R4: both flags together only when nothing is compared.
    a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && hit_inv) |-> (&mask));

endmodule

// File: tb/patmatch_acc_tb.sv
`timescale 1ns/1ps
module patmatch_acc_tb;
    import pd_pkg::*;

    localparam int W = 58;
    localparam int VW = 1 + W + W + 4;
    localparam int NV = 9;

    // {en, addend, expected acc, hit, hit_inv, ovf, udf}
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b1, 58'h080000000000000, 58'h080000000000000, 4'b1000},
        {1'b1, 58'h080000000000000, 58'h100000000000000, 4'b0010},
        {1'b1, 58'h000000000000000, 58'h100000000000000, 4'b0000},
        {1'b1, 58'h200000000000000, 58'h300000000000000, 4'b0100},
        {1'b1, 58'h300000000000000, 58'h200000000000000, 4'b0001},
        {1'b1, 58'h200000000000000, 58'h000000000000000, 4'b1000},
        {1'b1, 58'h3ffffffffffffff, 58'h3ffffffffffffff, 4'b0100},
        {1'b1, 58'h000000000000001, 58'h000000000000000, 4'b1000},
        {1'b0, 58'h100000000000000, 58'h000000000000000, 4'b1000}
    };

    logic clk = 1'b0;
    logic rst_n, acc_en, res_clr;
    logic [W-1:0] addend, cval;

    logic [W-1:0] p0, p1, p2, p3;
    logic h0, h1, h2, h3, i0, i1, i2, i3, o0, o1, o2, o3, u0, u1, u2, u3;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    // Default configuration: static pattern/mask, no automatic clear.
    patmatch_acc #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .res_clr(res_clr),
        .addend(addend), .cval(cval), .acc_out(p0), .hit(h0),
        .hit_inv(i0), .ovf(o0), .udf(u0));

    // Terminal counter: pattern 9, mask from cval, clear on hit, clear wins.
    patmatch_acc #(.W(W), .PATTERN_INIT(58'd9), .MASK_SRC(MSK_C),
        .AUTO_MODE(AR_ON_HIT), .AUTO_PRIO(PRIO_CLEAR)) u_cnt (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .res_clr(res_clr),
        .addend(addend), .cval(cval), .acc_out(p1), .hit(h1),
        .hit_inv(i1), .ovf(o1), .udf(u1));

    // Pattern from cval, mask ~cval<<1, clear on leave, enable gates.
    patmatch_acc #(.W(W), .PAT_SRC(PAT_C), .MASK_SRC(MSK_NC_SHL1),
        .AUTO_MODE(AR_ON_LEAVE), .AUTO_PRIO(PRIO_ENABLE)) u_rnd (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .res_clr(res_clr),
        .addend(addend), .cval(cval), .acc_out(p2), .hit(h2),
        .hit_inv(i2), .ovf(o2), .udf(u2));

    // Static zero pattern, mask ~cval<<2, no automatic clear.
    patmatch_acc #(.W(W), .MASK_SRC(MSK_NC_SHL2)) u_rnd2 (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .res_clr(res_clr),
        .addend(addend), .cval(cval), .acc_out(p3), .hit(h3),
        .hit_inv(i3), .ovf(o3), .udf(u3));

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_all();
        res_clr = 1'b1;
        acc_en  = 1'b0;
        step();
        res_clr = 1'b0;
    endtask

    initial begin
        #100us;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; acc_en = 1'b0; res_clr = 1'b0;
        addend = '0; cval = '0;
        repeat (3) step();
        rst_n = 1'b1;
        // R1 reset state
        check("R1 acc", 64'(p0), 64'd0);
        check("R1 flags", {60'd0, h0, i0, o0, u0}, {60'd0, 4'b1000});

        // Vector walk on default instance: R2 R3 R4 R10 R11
        for (int k = 0; k < NV; k++) begin
            acc_en = VEC[k][VW-1];
            addend = VEC[k][VW-2 -: W];
            step();
            check("R2 acc", 64'(p0), 64'(VEC[k][W+3:4]));
            check("R3 R4 R10 R11 flags", {60'd0, h0, i0, o0, u0}, {60'd0, VEC[k][3:0]});
        end

        // R1 synchronous clear from a nonzero value
        acc_en = 1'b1; addend = 58'h100000000000000;
        step();
        check("R10 ovf", 64'(o0), 64'd1);
        res_clr = 1'b1;
        step();
        res_clr = 1'b0;
        check("R1 clear acc", 64'(p0), 64'd0);
        check("R1 clear ovf", 64'(o0), 64'd0);

        // R7 terminal counter with mask from cval = 0
        cval = '0;
        clear_all();
        acc_en = 1'b1; addend = 58'd1;
        repeat (9) step();
        check("R7 reach 9", 64'(p1), 64'd9);
        check("R5 static pattern hit", 64'(h1), 64'd1);
        step();
        check("R7 auto clear", 64'(p1), 64'd0);
        // R9 clear wins over a low enable
        repeat (9) step();
        check("R9 reach 9", 64'(p1), 64'd9);
        acc_en = 1'b0;
        step();
        check("R9 clear wins", 64'(p1), 64'd0);

        // R6 mask taken from cval: ignore bit0 so 8 matches 9
        clear_all();
        acc_en = 1'b1;
        repeat (8) step();
        acc_en = 1'b0;
        check("R6 no hit at 8 with cval 0", 64'(h1), 64'd0);
        cval = 58'd1;
        #1;
        check("R6 mask from cval", 64'(h1), 64'd1);
        step();
        check("R7 clear after masked hit", 64'(p1), 64'd0);

        // R8 clear on leave, pattern and mask from cval (shift by 1)
        cval = 58'd7;
        clear_all();
        acc_en = 1'b1; addend = 58'd7;
        step();
        check("R5 R6 pattern from cval", 64'(h2), 64'd1);
        step();
        check("R8 leave value", 64'(p2), 64'd14);
        step();
        check("R8 clear on leave", 64'(p2), 64'd0);
        step();
        step();
        check("R9 prepared", 64'(p2), 64'd14);
        acc_en = 1'b0;
        step();
        check("R9 enable gates clear", 64'(p2), 64'd14);
        addend = 58'd1;
        #1;
        check("R4 inverse under cval", 64'(i2), 64'd0);

        // R6 mask ~cval<<2 with cval = 3: bits 3:0 compared
        cval = 58'd3;
        clear_all();
        acc_en = 1'b1; addend = 58'd8;
        step();
        check("R6 shl2 bit3 compared", 64'(h3), 64'd0);
        step();
        check("R6 shl2 hit at 16", 64'(h3), 64'd1);
        addend = 58'd1;
        step();
        check("R6 shl2 low bit compared", 64'(h3), 64'd0);
        acc_en = 1'b0;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule